// File: doc/BRIEF.md
# Serial NAND Bring-up Sequencer

This block runs once after every reset to bring a serial NAND device attached to a single-lane SPI port into a known, usable state. It drives the serial clock, chip select and data-out lines itself and reads the data-in line. It reads the three identification bytes and compares the first two against a small built-in table of supported parts. It clears the block-protection feature register. For parts that can move data over four lanes, it sets the part's quad-enable feature bit with a read-modify-write that writes back only when the bit is still clear.

When the sequence ends, the block holds its results on registered outputs until the next reset. These are a status code, the identification bytes, the cache-read and program-load opcodes and lane counts the rest of the controller must use, and the matched part's ECC strength and two spare-area offsets. Downstream logic waits for `init_done`, and may issue array traffic only while `init_ready` is high.

Top module: `spinand_bringup`

## Requirements
- R1: While reset is held and until the sequence ends, `init_done` and `init_ready` are 0, `init_status` is 2'b00 (pending), chip select is high, the serial clock is low, and the opcode, lane, ECC, offset and ID outputs are all 0.
- R2: Serial transfers use clock mode 0, most significant bit first. Each byte takes eight clock pulses. Chip select stays low across all bytes of one command and goes high between commands. While chip select is high, the serial clock stays low.
- R3: The first command is 0x9F followed by four 0x00 bytes. The reply bytes at positions 2, 3 and 4 are the ID bytes. `dev_id` shows them as {byte2, byte3, byte4} once the sequence ends, whatever the outcome.
- R4: If the first ID byte is 0xFF or 0x00, the sequence ends with `init_status` = 2'b10 (no device), and no further command is sent.
- R5: The key {ID byte 0, ID byte 1} is looked up in the part table. With no match, the sequence ends with `init_status` = 2'b11 (unsupported), and no further command is sent.
- R6: After a match, the block sends write-enable (the single byte 0x06), then set-feature 0x1F, 0xA0, 0x00, which clears block protection.
- R7: For a part with the quad-read flag and a quad-enable bit position other than 0xFF, the block sends get-feature 0x0F, address, 0x00 at the part's quad-enable address. Only if that bit reads back clear does it then send write-enable and set-feature 0x1F, address, with the value read OR-ed with (1 << bit).
- R8: When the quad-enable bit position is 0xFF, or the part lacks the quad-read flag, no get-feature and no second set-feature are sent.
- R9: By default, reads use opcode 0x03 on 1 lane and program loads use 0x02 on 1 lane. A part with the quad-read flag gets 0x6B on 4 lanes for reads. Program loads move to 0x32 on 4 lanes only when the part has the quad-program flag and quad read was chosen.
- R10: A successful sequence ends with `init_status` = 2'b01, `init_done` = 1 and `init_ready` = 1. It presents the matched part's ECC strength and spare offsets. On no device or unsupported, `init_ready`, the opcodes, the lanes and the geometry outputs stay 0. All outputs then hold until reset.
- R11: The part table holds the following entries, each given as key, quad-read flag, quad-program flag, QE address, QE bit, ECC strength, spare offset A, spare offset B:
  - 0xC8F1: 1, 1, 0xB0, 0, 1, 0x04, 0x08
  - 0xEFAA: 1, 1, 0xB0, 0xFF, 1, 0x04, 0x14
  - 0x98C2: 1, 0, 0xB0, 3, 8, 0x08, 0x0C
  - 0x2C12: 0, 0, 0xB0, 0xFF, 1, 0x04, 0x08
  - 0x2C14: 0, 1, 0xB0, 0xFF, 1, 0x04, 0x08

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; the sequence starts when it is released |
| spi_sclk | output | 1 | Serial clock, half the rate of `clk` |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the device |
| spi_miso | input | 1 | Serial data from the device |
| init_done | output | 1 | Sequence has ended (any outcome) |
| init_ready | output | 1 | Sequence ended with ok status |
| init_status | output | 2 | 00 pending, 01 ok, 10 no device, 11 unsupported |
| dev_id | output | 24 | The three ID bytes, first byte in the top bits |
| rd_opcode | output | 8 | Selected cache-read opcode |
| pl_opcode | output | 8 | Selected program-load opcode |
| rd_lanes | output | 3 | Read lane count (1 or 4) |
| pl_lanes | output | 3 | Program-load lane count (1 or 4) |
| ecc_strength | output | 4 | ECC strength of the matched part |
| spare_ofs_a | output | 8 | First spare-area offset of the matched part |
| spare_ofs_b | output | 8 | Second spare-area offset of the matched part |

## Verification
Every serial byte takes 18 clock cycles: 16 cycles of clock half-periods, one cycle for the completion pulse, and one cycle for the next start. The device model in the bench therefore reacts on serial clock edges rather than on cycle counts. It answers each bit on the falling serial edge, and the design samples it on the following rising one. As each command completes, when chip select rises, the monitor pops the expected command bytes from the scoreboard queue. The final outputs are registered on the edge after the last byte completes. The bench samples them on the falling clock edge once `init_done` is seen. It samples them again 40 cycles later to confirm that they hold and that no further command appeared.

// File: rtl/spinand_bringup_pkg.sv
package spinand_bringup_pkg;

  localparam int BYTE_W = 8;
  localparam int KEY_W  = 16;
  localparam int LANE_W = 3;
  localparam int ECC_W  = 4;
  localparam int KNOWN_PARTS = 5;

  localparam logic [BYTE_W-1:0] OP_READ_ID   = 8'h9F;
  localparam logic [BYTE_W-1:0] OP_WR_ENABLE = 8'h06;
  localparam logic [BYTE_W-1:0] OP_GET_FEAT  = 8'h0F;
  localparam logic [BYTE_W-1:0] OP_SET_FEAT  = 8'h1F;
  localparam logic [BYTE_W-1:0] OP_RD_X1     = 8'h03;
  localparam logic [BYTE_W-1:0] OP_RD_X4     = 8'h6B;
  localparam logic [BYTE_W-1:0] OP_LOAD_X1   = 8'h02;
  localparam logic [BYTE_W-1:0] OP_LOAD_X4   = 8'h32;
  localparam logic [BYTE_W-1:0] FEAT_PROTECT = 8'hA0;
  localparam logic [BYTE_W-1:0] QE_ABSENT    = 8'hFF;

  localparam logic [LANE_W-1:0] LANES_X1 = 3'd1;
  localparam logic [LANE_W-1:0] LANES_X4 = 3'd4;

  typedef enum logic [1:0] {
    INIT_PENDING = 2'b00,
    INIT_OK      = 2'b01,
    INIT_NODEV   = 2'b10,
    INIT_UNSUP   = 2'b11
  } init_status_e;

  typedef enum logic [1:0] {
    CMD_ID,
    CMD_WREN,
    CMD_SETF,
    CMD_GETF
  } cmd_kind_e;

  typedef struct packed {
    logic              quad_rd;
    logic              quad_pg;
    logic [BYTE_W-1:0] qe_addr;
    logic [BYTE_W-1:0] qe_bit;
    logic [ECC_W-1:0]  ecc;
    logic [BYTE_W-1:0] spare_a;
    logic [BYTE_W-1:0] spare_b;
  } part_cfg_t;

  typedef struct packed {
    logic [KEY_W-1:0] key;
    part_cfg_t        cfg;
  } part_t;

  typedef struct packed {
    logic [BYTE_W-1:0] rd_op;
    logic [BYTE_W-1:0] pg_op;
    logic [LANE_W-1:0] rd_lanes;
    logic [LANE_W-1:0] pg_lanes;
  } lane_cfg_t;

  function automatic part_t part_entry(input int idx);
    part_t p;
    case (idx)
      0:       p = '{key: 16'hC8F1, cfg: '{1'b1, 1'b1, 8'hB0, 8'h00, 4'd1, 8'h04, 8'h08}};
      1:       p = '{key: 16'hEFAA, cfg: '{1'b1, 1'b1, 8'hB0, 8'hFF, 4'd1, 8'h04, 8'h14}};
      2:       p = '{key: 16'h98C2, cfg: '{1'b1, 1'b0, 8'hB0, 8'h03, 4'd8, 8'h08, 8'h0C}};
      3:       p = '{key: 16'h2C12, cfg: '{1'b0, 1'b0, 8'hB0, 8'hFF, 4'd1, 8'h04, 8'h08}};
      4:       p = '{key: 16'h2C14, cfg: '{1'b0, 1'b1, 8'hB0, 8'hFF, 4'd1, 8'h04, 8'h08}};
      default: p = '0;
    endcase
    return p;
  endfunction

  function automatic logic [2:0] cmd_length(input cmd_kind_e k);
    case (k)
      CMD_ID:   return 3'd5;
      CMD_WREN: return 3'd1;
      default:  return 3'd3;
    endcase
  endfunction

  function automatic logic [BYTE_W-1:0] cmd_byte(input cmd_kind_e k, input logic [2:0] idx,
                                                 input logic [BYTE_W-1:0] faddr,
                                                 input logic [BYTE_W-1:0] fdata);
    logic [BYTE_W-1:0] b;
    b = '0;
    case (k)
      CMD_ID:   if (idx == 3'd0) b = OP_READ_ID;
      CMD_WREN: b = OP_WR_ENABLE;
      CMD_SETF: b = (idx == 3'd0) ? OP_SET_FEAT : (idx == 3'd1) ? faddr : fdata;
      CMD_GETF: b = (idx == 3'd0) ? OP_GET_FEAT : (idx == 3'd1) ? faddr : '0;
      default:  b = '0;
    endcase
    return b;
  endfunction

  function automatic logic [BYTE_W-1:0] qe_mask(input logic [BYTE_W-1:0] bitpos);
    return 8'h01 << bitpos[2:0];
  endfunction

  function automatic logic absent_device(input logic [BYTE_W-1:0] first_id);
    return (first_id == 8'hFF) || (first_id == 8'h00);
  endfunction

  function automatic lane_cfg_t pick_lanes(input logic quad_rd_on, input logic quad_pg_flag);
    lane_cfg_t c;
    c.rd_op    = quad_rd_on ? OP_RD_X4 : OP_RD_X1;
    c.rd_lanes = quad_rd_on ? LANES_X4 : LANES_X1;
    c.pg_op    = (quad_rd_on && quad_pg_flag) ? OP_LOAD_X4 : OP_LOAD_X1;
    c.pg_lanes = (quad_rd_on && quad_pg_flag) ? LANES_X4 : LANES_X1;
    return c;
  endfunction

endpackage

// File: rtl/spinand_bringup_shifter.sv
module spinand_bringup_shifter #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic              last,
  input  logic              miso,
  output logic              sclk,
  output logic              cs_n,
  output logic              mosi,
  output logic              busy,
  output logic              byte_done,
  output logic [BYTE_W-1:0] rx_byte
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(BYTE_W - 1);

  logic              active_q, phase_q, last_q, sclk_q, cs_n_q, done_q;
  logic [CNT_W-1:0]  bit_q;
  logic [BYTE_W-1:0] tx_q, rx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      phase_q  <= 1'b0;
      last_q   <= 1'b0;
      sclk_q   <= 1'b0;
      cs_n_q   <= 1'b1;
      done_q   <= 1'b0;
      bit_q    <= '0;
      tx_q     <= '0;
      rx_q     <= '0;
    end else begin
      done_q <= 1'b0;
      if (!active_q) begin
        if (start) begin
          active_q <= 1'b1;
          cs_n_q   <= 1'b0;
          tx_q     <= tx_byte;
          last_q   <= last;
          phase_q  <= 1'b0;
          bit_q    <= '0;
          sclk_q   <= 1'b0;
        end
      end else if (!phase_q) begin
        sclk_q  <= 1'b1;
        rx_q    <= {rx_q[BYTE_W-2:0], miso};
        phase_q <= 1'b1;
      end else begin
        sclk_q  <= 1'b0;
        phase_q <= 1'b0;
        if (bit_q == BIT_LAST) begin
          active_q <= 1'b0;
          done_q   <= 1'b1;
          if (last_q) cs_n_q <= 1'b1;
        end else begin
          bit_q <= bit_q + 1'b1;
          tx_q  <= {tx_q[BYTE_W-2:0], 1'b0};
        end
      end
    end
  end

  assign sclk      = sclk_q;
  assign cs_n      = cs_n_q;
  assign mosi      = tx_q[BYTE_W-1];
  assign busy      = active_q;
  assign byte_done = done_q;
  assign rx_byte   = rx_q;
endmodule

// File: rtl/spinand_bringup_lookup.sv
module spinand_bringup_lookup
  import spinand_bringup_pkg::*;
#(
  parameter int NUM_PARTS = KNOWN_PARTS
) (
  input  logic [KEY_W-1:0] key,
  output logic             hit,
  output part_cfg_t        cfg
);
  part_t                tbl   [NUM_PARTS];
  logic [NUM_PARTS-1:0] match;

  for (genvar g = 0; g < NUM_PARTS; g++) begin : g_entry
    assign tbl[g]   = part_entry(g);
    assign match[g] = (tbl[g].key == key);
  end

  always_comb begin
    hit = 1'b0;
    cfg = '0;
    for (int i = NUM_PARTS - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit = 1'b1;
        cfg = tbl[i].cfg;
      end
    end
  end
endmodule

// File: rtl/spinand_bringup_seq.sv
module spinand_bringup_seq
  import spinand_bringup_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                byte_done,
  input  logic [BYTE_W-1:0]   rx_byte,
  input  logic                hit,
  input  part_cfg_t           cfg,
  output logic                start,
  output logic [BYTE_W-1:0]   tx_byte,
  output logic                last,
  output logic [KEY_W-1:0]    key,
  output logic                finish,
  output logic                init_done,
  output logic                init_ready,
  output logic [1:0]          init_status,
  output logic [3*BYTE_W-1:0] dev_id,
  output logic [BYTE_W-1:0]   rd_opcode,
  output logic [BYTE_W-1:0]   pl_opcode,
  output logic [LANE_W-1:0]   rd_lanes,
  output logic [LANE_W-1:0]   pl_lanes,
  output logic [ECC_W-1:0]    ecc_strength,
  output logic [BYTE_W-1:0]   spare_ofs_a,
  output logic [BYTE_W-1:0]   spare_ofs_b
);
  typedef enum logic [3:0] {
    S_BOOT, S_RDID, S_EVAL, S_WREN_A, S_UNLOCK, S_QE_PLAN,
    S_QE_GET, S_QE_EVAL, S_WREN_B, S_QE_SET, S_DONE, S_HALT
  } seq_state_e;

  seq_state_e        state_q;
  cmd_kind_e         kind;
  logic              in_cmd, wait_q, qe_ok_q;
  logic [2:0]        bcnt_q;
  logic [BYTE_W-1:0] id0_q, id1_q, id2_q, faddr_q, fdata_q;
  init_status_e      fin_q;
  part_cfg_t         part_q;
  lane_cfg_t         lanes;

  always_comb begin
    in_cmd = 1'b1;
    kind   = CMD_WREN;
    case (state_q)
      S_RDID:             kind = CMD_ID;
      S_WREN_A, S_WREN_B: kind = CMD_WREN;
      S_UNLOCK, S_QE_SET: kind = CMD_SETF;
      S_QE_GET:           kind = CMD_GETF;
      default:            in_cmd = 1'b0;
    endcase
  end

  assign start   = in_cmd && !wait_q;
  assign tx_byte = cmd_byte(kind, bcnt_q, faddr_q, fdata_q);
  assign last    = (bcnt_q == cmd_length(kind) - 3'd1);
  assign key     = {id0_q, id1_q};
  assign finish  = (state_q == S_DONE);
  assign lanes   = pick_lanes(qe_ok_q && part_q.quad_rd, part_q.quad_pg);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_BOOT;
      wait_q  <= 1'b0;
      bcnt_q  <= '0;
      qe_ok_q <= 1'b0;
      id0_q   <= '0;
      id1_q   <= '0;
      id2_q   <= '0;
      faddr_q <= '0;
      fdata_q <= '0;
      fin_q   <= INIT_PENDING;
      part_q  <= '0;
    end else begin
      if (start) wait_q <= 1'b1;
      if (in_cmd && byte_done) begin
        wait_q <= 1'b0;
        bcnt_q <= last ? 3'd0 : bcnt_q + 3'd1;
      end
      case (state_q)
        S_BOOT: state_q <= S_RDID;
        S_RDID: if (byte_done) begin
          case (bcnt_q)
            3'd2:    id0_q <= rx_byte;
            3'd3:    id1_q <= rx_byte;
            3'd4:    id2_q <= rx_byte;
            default: ;
          endcase
          if (last) state_q <= S_EVAL;
        end
        S_EVAL: begin
          if (absent_device(id0_q)) begin
            fin_q   <= INIT_NODEV;
            state_q <= S_DONE;
          end else if (!hit) begin
            fin_q   <= INIT_UNSUP;
            state_q <= S_DONE;
          end else begin
            part_q  <= cfg;
            faddr_q <= FEAT_PROTECT;
            fdata_q <= '0;
            state_q <= S_WREN_A;
          end
        end
        S_WREN_A: if (byte_done) state_q <= S_UNLOCK;
        S_UNLOCK: if (byte_done && last) state_q <= S_QE_PLAN;
        S_QE_PLAN: begin
          if (!part_q.quad_rd || part_q.qe_bit == QE_ABSENT) begin
            qe_ok_q <= part_q.quad_rd;
            fin_q   <= INIT_OK;
            state_q <= S_DONE;
          end else begin
            faddr_q <= part_q.qe_addr;
            state_q <= S_QE_GET;
          end
        end
        S_QE_GET: if (byte_done) begin
          if (bcnt_q == 3'd2) fdata_q <= rx_byte;
          if (last) state_q <= S_QE_EVAL;
        end
        S_QE_EVAL: begin
          if ((fdata_q & qe_mask(part_q.qe_bit)) != '0) begin
            qe_ok_q <= 1'b1;
            fin_q   <= INIT_OK;
            state_q <= S_DONE;
          end else begin
            fdata_q <= fdata_q | qe_mask(part_q.qe_bit);
            state_q <= S_WREN_B;
          end
        end
        S_WREN_B: if (byte_done) state_q <= S_QE_SET;
        S_QE_SET: if (byte_done && last) begin
          qe_ok_q <= 1'b1;
          fin_q   <= INIT_OK;
          state_q <= S_DONE;
        end
        S_DONE:  state_q <= S_HALT;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      init_done    <= 1'b0;
      init_ready   <= 1'b0;
      init_status  <= INIT_PENDING;
      dev_id       <= '0;
      rd_opcode    <= '0;
      pl_opcode    <= '0;
      rd_lanes     <= '0;
      pl_lanes     <= '0;
      ecc_strength <= '0;
      spare_ofs_a  <= '0;
      spare_ofs_b  <= '0;
    end else if (finish) begin
      init_done   <= 1'b1;
      init_status <= fin_q;
      dev_id      <= {id0_q, id1_q, id2_q};
      if (fin_q == INIT_OK) begin
        init_ready   <= 1'b1;
        rd_opcode    <= lanes.rd_op;
        pl_opcode    <= lanes.pg_op;
        rd_lanes     <= lanes.rd_lanes;
        pl_lanes     <= lanes.pg_lanes;
        ecc_strength <= part_q.ecc;
        spare_ofs_a  <= part_q.spare_a;
        spare_ofs_b  <= part_q.spare_b;
      end
    end
  end
endmodule

// File: rtl/spinand_bringup.sv
module spinand_bringup
  import spinand_bringup_pkg::*;
#(
  parameter int NUM_PARTS = KNOWN_PARTS
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic        spi_sclk,
  output logic        spi_cs_n,
  output logic        spi_mosi,
  input  logic        spi_miso,
  output logic        init_done,
  output logic        init_ready,
  output logic [1:0]  init_status,
  output logic [23:0] dev_id,
  output logic [7:0]  rd_opcode,
  output logic [7:0]  pl_opcode,
  output logic [2:0]  rd_lanes,
  output logic [2:0]  pl_lanes,
  output logic [3:0]  ecc_strength,
  output logic [7:0]  spare_ofs_a,
  output logic [7:0]  spare_ofs_b
);
  logic              seq_start, seq_last, sh_busy, sh_done, lk_hit, seq_finish;
  logic [BYTE_W-1:0] seq_tx, sh_rx;
  logic [KEY_W-1:0]  lk_key;
  part_cfg_t         lk_cfg;

  spinand_bringup_shifter #(.BYTE_W(BYTE_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(seq_start), .tx_byte(seq_tx), .last(seq_last),
    .miso(spi_miso), .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi),
    .busy(sh_busy), .byte_done(sh_done), .rx_byte(sh_rx)
  );

  spinand_bringup_lookup #(.NUM_PARTS(NUM_PARTS)) u_lookup (
    .key(lk_key), .hit(lk_hit), .cfg(lk_cfg)
  );

  spinand_bringup_seq u_seq (
    .clk(clk), .rst_n(rst_n), .byte_done(sh_done), .rx_byte(sh_rx),
    .hit(lk_hit), .cfg(lk_cfg), .start(seq_start), .tx_byte(seq_tx), .last(seq_last),
    .key(lk_key), .finish(seq_finish), .init_done(init_done), .init_ready(init_ready),
    .init_status(init_status), .dev_id(dev_id), .rd_opcode(rd_opcode),
    .pl_opcode(pl_opcode), .rd_lanes(rd_lanes), .pl_lanes(pl_lanes),
    .ecc_strength(ecc_strength), .spare_ofs_a(spare_ofs_a), .spare_ofs_b(spare_ofs_b)
  );
endmodule

// File: rtl/spinand_bringup_chk.sv
module spinand_bringup_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       spi_sclk,
  input logic       spi_cs_n,
  input logic       init_done,
  input logic       init_ready,
  input logic [1:0] init_status,
  input logic [7:0] rd_opcode,
  input logic [7:0] pl_opcode,
  input logic [2:0] rd_lanes,
  input logic [2:0] pl_lanes,
  input logic       seq_start,
  input logic       sh_busy,
  input logic       seq_finish
);
  p_pending_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> (init_status == 2'b00 && !init_ready && rd_lanes == 3'd0));

  p_sclk_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk);

  p_no_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    seq_start |-> !sh_busy);

  p_quiet_after_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (init_done || seq_finish) |-> (spi_cs_n && !sh_busy));

  p_quad_pl_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pl_lanes == 3'd4) |-> (rd_lanes == 3'd4 && pl_opcode == 8'h32));

  p_quad_rd_op_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lanes == 3'd4) |-> (rd_opcode == 8'h6B));

  p_ready_ok_r10: assert property (@(posedge clk) disable iff (!rst_n)
    init_ready |-> (init_done && init_status == 2'b01));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> (init_done && $stable(init_status) && $stable(init_ready) &&
                   $stable(rd_opcode) && $stable(pl_opcode)));
endmodule

bind spinand_bringup spinand_bringup_chk u_chk (
  .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
  .init_done(init_done), .init_ready(init_ready), .init_status(init_status),
  .rd_opcode(rd_opcode), .pl_opcode(pl_opcode), .rd_lanes(rd_lanes), .pl_lanes(pl_lanes),
  .seq_start(seq_start), .sh_busy(sh_busy), .seq_finish(seq_finish)
);

// File: tb/spinand_bringup_test.sv
module spinand_bringup_test;
  logic        clk, rst_n;
  logic        spi_sclk, spi_cs_n, spi_mosi, spi_miso;
  logic        init_done, init_ready;
  logic [1:0]  init_status;
  logic [23:0] dev_id;
  logic [7:0]  rd_opcode, pl_opcode, spare_ofs_a, spare_ofs_b;
  logic [2:0]  rd_lanes, pl_lanes;
  logic [3:0]  ecc_strength;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  spinand_bringup uut (
    .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .init_done(init_done),
    .init_ready(init_ready), .init_status(init_status), .dev_id(dev_id),
    .rd_opcode(rd_opcode), .pl_opcode(pl_opcode), .rd_lanes(rd_lanes),
    .pl_lanes(pl_lanes), .ecc_strength(ecc_strength), .spare_ofs_a(spare_ofs_a),
    .spare_ofs_b(spare_ofs_b)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // ---------------- device model ----------------
  logic [7:0] id_b [3];
  logic [7:0] feat [256];
  logic [7:0] got  [8];
  logic [7:0] sh_in;
  logic       miso_drv;
  int         bitc;
  assign spi_miso = miso_drv;

  function automatic logic [7:0] reply(input int idx);
    if (got[0] == 8'h9F && idx >= 2 && idx <= 4) return id_b[idx-2];
    if (got[0] == 8'h0F && idx == 2) return feat[got[1]];
    return 8'h00;
  endfunction

  always @(negedge spi_cs_n) begin
    bitc = 0;
    for (int i = 0; i < 8; i++) got[i] = 8'h00;
  end

  always @(posedge spi_sclk) begin
    if (!spi_cs_n) begin
      sh_in = {sh_in[6:0], spi_mosi};
      bitc++;
      if (bitc % 8 == 0 && bitc <= 64) begin
        got[bitc/8 - 1] = sh_in;
        if (bitc == 24 && got[0] == 8'h1F) feat[got[1]] = sh_in;
      end
    end
  end

  always @(negedge spi_sclk) begin
    if (!spi_cs_n) begin
      logic [7:0] r;
      r = reply(bitc / 8);
      miso_drv = r[7 - (bitc % 8)];
    end
  end

  // ---------------- scoreboard ----------------
  logic [31:0] exp_q [$];

  task automatic expect_cmd(input logic [7:0] n, input logic [7:0] b0,
                            input logic [7:0] b1, input logic [7:0] b2);
    exp_q.push_back({n, b0, b1, b2});
  endtask

  always @(posedge spi_cs_n) begin
    if (bitc != 0) begin
      logic [31:0] seen;
      seen = {8'(bitc / 8), got[0], got[1], got[2]};
      if (exp_q.size() == 0) begin
        chk("R2/R4/R8 unexpected command", seen, 32'h0);
      end else begin
        chk("R2/R3/R6/R7 command bytes", seen, exp_q.pop_front());
      end
      bitc = 0;
    end
  end

  task automatic start_case(input logic [7:0] i0, input logic [7:0] i1, input logic [7:0] i2,
                            input logic [7:0] b0_init);
    rst_n = 1'b0;
    id_b[0] = i0; id_b[1] = i1; id_b[2] = i2;
    for (int i = 0; i < 256; i++) feat[i] = 8'h00;
    feat[8'hA0] = 8'h7C;
    feat[8'hB0] = b0_init;
    miso_drv = 1'b0;
    exp_q.delete();
    repeat (3) @(negedge clk);
    expect_cmd(8'd5, 8'h9F, 8'h00, 8'h00);
  endtask

  task automatic run_and_check(input string tag, input logic [1:0] st, input logic [23:0] idv,
                               input logic [7:0] rop, input logic [7:0] pop,
                               input logic [2:0] rl, input logic [2:0] pl, input logic [3:0] ecc,
                               input logic [7:0] sa, input logic [7:0] sb);
    logic [63:0] snap;
    rst_n = 1'b1;
    for (int i = 0; i < 5000 && !init_done; i++) @(negedge clk);
    chk({tag, " R10 init_done"}, 32'(init_done), 32'd1);
    chk({tag, " R4/R5/R10 status"}, 32'(init_status), 32'(st));
    chk({tag, " R10 ready"}, 32'(init_ready), 32'(st == 2'b01));
    chk({tag, " R3 dev_id"}, 32'(dev_id), 32'(idv));
    chk({tag, " R9 rd op/lanes"}, {16'h0, rop, 5'h0, rl}, {16'h0, rd_opcode, 5'h0, rd_lanes});
    chk({tag, " R9 pl op/lanes"}, {16'h0, pop, 5'h0, pl}, {16'h0, pl_opcode, 5'h0, pl_lanes});
    chk({tag, " R10 R11 geometry"}, {12'h0, ecc, sa, sb}, {12'h0, ecc_strength, spare_ofs_a, spare_ofs_b});
    snap = {init_status, init_ready, dev_id, rd_opcode, pl_opcode, rd_lanes, pl_lanes, 8'h0};
    repeat (40) @(negedge clk);
    chk({tag, " R10 outputs hold"},
        32'({init_status, init_ready, dev_id, rd_opcode, pl_opcode, rd_lanes, pl_lanes, 8'h0} == snap), 32'd1);
    chk({tag, " R4/R5/R8 all commands seen"}, 32'(exp_q.size()), 32'd0);
  endtask

  initial begin
    rst_n = 1'b0;
    miso_drv = 1'b0;
    bitc = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset done/ready", {30'h0, init_done, init_ready}, 32'h0);
    chk("R1 reset status", 32'(init_status), 32'h0);
    chk("R1 reset cs/sclk", {30'h0, spi_cs_n, spi_sclk}, 32'h2);
    chk("R1 reset outputs", {rd_opcode, pl_opcode, 2'b0, rd_lanes, pl_lanes, ecc_strength}, 32'h0);

    // R4 first byte 0xFF
    start_case(8'hFF, 8'h12, 8'h34, 8'h00);
    run_and_check("nodev_ff", 2'b10, 24'hFF1234, 8'h00, 8'h00, 3'd0, 3'd0, 4'd0, 8'h00, 8'h00);
    // R4 first byte 0x00
    start_case(8'h00, 8'hC8, 8'h01, 8'h00);
    run_and_check("nodev_00", 2'b10, 24'h00C801, 8'h00, 8'h00, 3'd0, 3'd0, 4'd0, 8'h00, 8'h00);
    // R5 unknown key
    start_case(8'hC8, 8'h22, 8'h5A, 8'h00);
    run_and_check("unsup", 2'b11, 24'hC8225A, 8'h00, 8'h00, 3'd0, 3'd0, 4'd0, 8'h00, 8'h00);

    // R6 R7 QE bit clear: read-modify-write of bit 0
    start_case(8'hC8, 8'hF1, 8'h7E, 8'h00);
    expect_cmd(8'd1, 8'h06, 8'h00, 8'h00);
    expect_cmd(8'd3, 8'h1F, 8'hA0, 8'h00);
    expect_cmd(8'd3, 8'h0F, 8'hB0, 8'h00);
    expect_cmd(8'd1, 8'h06, 8'h00, 8'h00);
    expect_cmd(8'd3, 8'h1F, 8'hB0, 8'h01);
    run_and_check("qe_clear", 2'b01, 24'hC8F17E, 8'h6B, 8'h32, 3'd4, 3'd4, 4'd1, 8'h04, 8'h08);
    chk("R6 protect register cleared", 32'(feat[8'hA0]), 32'h00);
    chk("R7 QE bit set", 32'(feat[8'hB0]), 32'h01);

    // R7 QE bit already set: no write back
    start_case(8'hC8, 8'hF1, 8'h00, 8'h05);
    expect_cmd(8'd1, 8'h06, 8'h00, 8'h00);
    expect_cmd(8'd3, 8'h1F, 8'hA0, 8'h00);
    expect_cmd(8'd3, 8'h0F, 8'hB0, 8'h00);
    run_and_check("qe_set", 2'b01, 24'hC8F100, 8'h6B, 8'h32, 3'd4, 3'd4, 4'd1, 8'h04, 8'h08);
    chk("R7 QE register untouched", 32'(feat[8'hB0]), 32'h05);

    // R8 QE position 0xFF: no feature access beyond unlock
    start_case(8'hEF, 8'hAA, 8'h21, 8'h40);
    expect_cmd(8'd1, 8'h06, 8'h00, 8'h00);
    expect_cmd(8'd3, 8'h1F, 8'hA0, 8'h00);
    run_and_check("qe_none", 2'b01, 24'hEFAA21, 8'h6B, 8'h32, 3'd4, 3'd4, 4'd1, 8'h04, 8'h14);
    chk("R8 QE register untouched", 32'(feat[8'hB0]), 32'h40);

    // R7 R9 quad read only, QE bit 3
    start_case(8'h98, 8'hC2, 8'h00, 8'h10);
    expect_cmd(8'd1, 8'h06, 8'h00, 8'h00);
    expect_cmd(8'd3, 8'h1F, 8'hA0, 8'h00);
    expect_cmd(8'd3, 8'h0F, 8'hB0, 8'h00);
    expect_cmd(8'd1, 8'h06, 8'h00, 8'h00);
    expect_cmd(8'd3, 8'h1F, 8'hB0, 8'h18);
    run_and_check("quad_rd_only", 2'b01, 24'h98C200, 8'h6B, 8'h02, 3'd4, 3'd1, 4'd8, 8'h08, 8'h0C);
    chk("R7 QE bit 3 merged", 32'(feat[8'hB0]), 32'h18);

    // R8 R9 no quad at all
    start_case(8'h2C, 8'h12, 8'h00, 8'h00);
    expect_cmd(8'd1, 8'h06, 8'h00, 8'h00);
    expect_cmd(8'd3, 8'h1F, 8'hA0, 8'h00);
    run_and_check("single", 2'b01, 24'h2C1200, 8'h03, 8'h02, 3'd1, 3'd1, 4'd1, 8'h04, 8'h08);

    // R9 quad program flag without quad read stays single
    start_case(8'h2C, 8'h14, 8'h00, 8'h00);
    expect_cmd(8'd1, 8'h06, 8'h00, 8'h00);
    expect_cmd(8'd3, 8'h1F, 8'hA0, 8'h00);
    run_and_check("pg_flag_only", 2'b01, 24'h2C1400, 8'h03, 8'h02, 3'd1, 3'd1, 4'd1, 8'h04, 8'h08);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule